// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Context Shadow

This block keeps return addresses for a small 4-bit controller core. It has a circular store of program-counter entries and a pointer register. Three sources push an entry: a subroutine call, an interrupt entry and a table-reference instruction. Three sources pop one: a return, a return-from-interrupt and the end of a table reference. Each push uses one level of the store, whichever source made it.

Before each write the pointer moves up by one. A pop reads the entry the pointer selects and then moves the pointer down by one. The pointer wraps at both ends and gives no error indication. If the core nests deeper than the store allows, the oldest entries are overwritten. The pointer value is always visible on an output, so an instruction can copy it into the accumulator.

A separate one-stage shadow register holds the core's context across an interrupt: the data pointer, the carry, the skip flag, and the A and B nibbles. Only an interrupt entry writes the shadow. Only a return-from-interrupt presents its contents on the restore outputs.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst` is high and in the cycle after, `sp_o` is DEPTH-1 (7 by default), and `pc_vld_o` and `ctx_vld_o` are 0.
- R2: A cycle with any push request (`call_i`, `irq_i` or `tbl_i`) and no `resume_i` raises `sp_o` by one in the next cycle, with 7 wrapping to 0.
- R3: A push writes `pc_i` into the entry at the advanced pointer, so the first push after reset fills entry 0. A pop returns the entries in last-in first-out order on `pc_o`, with `pc_vld_o` high for exactly the one cycle after the pop request.
- R4: A ninth push made while `sp_o` is 7 moves the pointer to 0 and overwrites entry 0, with no error indication. The next pop returns the ninth address. The pop after that returns the eighth.
- R5: A pop (`ret_i`, `reti_i` or `tbl_end_i`) with no push and no `resume_i` reads the entry at the current pointer and lowers `sp_o` by one in the next cycle, with 0 wrapping to 7. A pop on an empty stack wraps silently.
- R6: A call, an interrupt entry and a table reference each use exactly one stack level.
- R7: An interrupt entry captures the data pointer, carry, skip flag, A and B into the shadow. Calls and table references leave the shadow unchanged.
- R8: A return-from-interrupt pops the stack. In the same cycle as its `pc_vld_o`, it raises `ctx_vld_o` and presents the shadow on `dp_o`, `carry_o`, `skip_o`, `a_o` and `b_o`. The other pops keep `ctx_vld_o` low.
- R9: The shadow is one stage deep. A second interrupt entry overwrites it, and every later restore presents the most recent capture.
- R10: When a push and a pop are requested in the same cycle, the push is performed and the pop is dropped: `sp_o` rises by one and `pc_vld_o` stays low.
- R11: A `resume_i` pulse sets `sp_o` to DEPTH-1 in the next cycle. Any push or pop requested in that cycle is ignored, and the stored entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resume_i | input | 1 | Exit from back-up mode; sets the pointer to the top |
| call_i | input | 1 | Push request from a subroutine call |
| irq_i | input | 1 | Push request from an interrupt entry; also captures the context |
| tbl_i | input | 1 | Push request from a table reference |
| ret_i | input | 1 | Pop request from a return |
| reti_i | input | 1 | Pop request from a return-from-interrupt; also restores the context |
| tbl_end_i | input | 1 | Pop request at the end of a table reference |
| pc_i | input | PC_W | Address to push |
| dp_i | input | 6 | Data pointer to shadow |
| carry_i | input | 1 | Carry flag to shadow |
| skip_i | input | 1 | Skip flag to shadow |
| a_i | input | 4 | Register A to shadow |
| b_i | input | 4 | Register B to shadow |
| sp_o | output | SP_W | Current stack pointer |
| pc_o | output | PC_W | Popped address |
| pc_vld_o | output | 1 | `pc_o` is valid |
| ctx_vld_o | output | 1 | The restore outputs are valid |
| dp_o | output | 6 | Restored data pointer |
| carry_o | output | 1 | Restored carry |
| skip_o | output | 1 | Restored skip flag |
| a_o | output | 4 | Restored register A |
| b_o | output | 4 | Restored register B |

## Verification
Every result is due exactly one clock after its request. `sp_o` changes one cycle after a push, pop or resume. `pc_o`, `pc_vld_o` and the restore outputs come out of the registered read port one cycle after the pop. The bench drives each request on a falling edge and holds it across one rising edge. It then samples on the next falling edge, which is the one cycle where the pop results are valid. A separate check confirms that `pc_vld_o` has dropped again by the following cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned DP_W  = 6;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic [DP_W-1:0]  dp;
    logic             carry;
    logic             skip;
    logic [NIB_W-1:0] a;
    logic [NIB_W-1:0] b;
  } ctx_t;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SP_W  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            resume_i,
  input  logic            push_i,
  input  logic            pop_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] wr_idx_o,
  output logic [SP_W-1:0] rd_idx_o
);
  localparam logic [SP_W-1:0] TOP = SP_W'(DEPTH - 1);

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_up;
  logic [SP_W-1:0] sp_dn;

  always_comb begin
    sp_up = (sp_q == TOP) ? '0 : sp_q + SP_W'(1);
    sp_dn = (sp_q == '0) ? TOP : sp_q - SP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || resume_i) begin
      sp_q <= TOP;
    end else if (push_i) begin
      sp_q <= sp_up;
    end else if (pop_i) begin
      sp_q <= sp_dn;
    end
  end

  assign sp_o     = sp_q;
  assign wr_idx_o = sp_up;
  assign rd_idx_o = sp_q;
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int unsigned PC_W  = 14,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SP_W  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we_i,
  input  logic [SP_W-1:0] waddr_i,
  input  logic [PC_W-1:0] wdata_i,
  input  logic            re_i,
  input  logic [SP_W-1:0] raddr_i,
  output logic [PC_W-1:0] rdata_o
);
  logic [PC_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      store[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_o <= store[raddr_i];
    end
  end
endmodule

// File: rtl/ras_ctx_shadow.sv
module ras_ctx_shadow
  import ras_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  ctx_t ctx_i,
  input  logic restore_i,
  output ctx_t held_o,
  output ctx_t ctx_o,
  output logic vld_o
);
  ctx_t held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      ctx_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      if (cap_i) begin
        held_q <= ctx_i;
      end
      vld_o <= restore_i;
      if (restore_i) begin
        ctx_o <= held_q;
      end
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int unsigned PC_W  = 14,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SP_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resume_i,
  input  logic             call_i,
  input  logic             irq_i,
  input  logic             tbl_i,
  input  logic             ret_i,
  input  logic             reti_i,
  input  logic             tbl_end_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DP_W-1:0]  dp_i,
  input  logic             carry_i,
  input  logic             skip_i,
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  output logic [SP_W-1:0]  sp_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             pc_vld_o,
  output logic             ctx_vld_o,
  output logic [DP_W-1:0]  dp_o,
  output logic             carry_o,
  output logic             skip_o,
  output logic [NIB_W-1:0] a_o,
  output logic [NIB_W-1:0] b_o
);
  logic            any_push;
  logic            any_pop;
  logic            push_go;
  logic            pop_go;
  logic [SP_W-1:0] wr_idx;
  logic [SP_W-1:0] rd_idx;
  ctx_t            ctx_in;
  ctx_t            ctx_out;
  ctx_t            shadow_q;

  always_comb begin
    any_push = call_i | irq_i | tbl_i;
    any_pop  = ret_i | reti_i | tbl_end_i;
    push_go  = any_push & ~resume_i;
    pop_go   = any_pop & ~any_push & ~resume_i;
  end

  assign ctx_in = '{dp: dp_i, carry: carry_i, skip: skip_i, a: a_i, b: b_i};

  ras_ptr #(.DEPTH(DEPTH), .SP_W(SP_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .resume_i (resume_i),
    .push_i   (push_go),
    .pop_i    (pop_go),
    .sp_o     (sp_o),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx)
  );

  ras_mem #(.PC_W(PC_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_mem (
    .clk     (clk),
    .we_i    (push_go),
    .waddr_i (wr_idx),
    .wdata_i (pc_i),
    .re_i    (pop_go),
    .raddr_i (rd_idx),
    .rdata_o (pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_vld_o <= 1'b0;
    end else begin
      pc_vld_o <= pop_go;
    end
  end

  ras_ctx_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .cap_i     (push_go & irq_i),
    .ctx_i     (ctx_in),
    .restore_i (pop_go & reti_i),
    .held_o    (shadow_q),
    .ctx_o     (ctx_out),
    .vld_o     (ctx_vld_o)
  );

  assign dp_o    = ctx_out.dp;
  assign carry_o = ctx_out.carry;
  assign skip_o  = ctx_out.skip;
  assign a_o     = ctx_out.a;
  assign b_o     = ctx_out.b;
endmodule

// File: rtl/ras_checker.sv
module ras_checker
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SP_W  = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst,
  input logic            resume_i,
  input logic            call_i,
  input logic            irq_i,
  input logic            tbl_i,
  input logic            ret_i,
  input logic            reti_i,
  input logic            tbl_end_i,
  input logic [SP_W-1:0] sp_o,
  input logic            pc_vld_o,
  input logic            ctx_vld_o,
  input ctx_t            shadow_q
);
  logic psh, pop;
  assign psh = call_i | irq_i | tbl_i;
  assign pop = ret_i | reti_i | tbl_end_i;

  AST_RESET_TOP: assert property (@(posedge clk) rst |=> (sp_o == SP_W'(DEPTH-1)) && !pc_vld_o && !ctx_vld_o); // R1
  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (psh && !resume_i) |=> sp_o == ((($past(sp_o)) == SP_W'(DEPTH-1)) ? '0 : SP_W'($past(sp_o) + 1'b1))); // R2
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
    (pop && !psh && !resume_i) |=> sp_o == ((($past(sp_o)) == '0) ? SP_W'(DEPTH-1) : SP_W'($past(sp_o) - 1'b1))); // R5
  AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
    (pop && !psh && !resume_i) |=> pc_vld_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(pop && !psh && !resume_i) |=> !pc_vld_o); // R3
  AST_RESTORE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    ctx_vld_o |-> pc_vld_o); // R8
  AST_RESTORE_ON_RETI: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !psh && !resume_i) |=> ctx_vld_o); // R8
  AST_SHADOW_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !irq_i |=> $stable(shadow_q)); // R7
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    (psh && pop) |=> !pc_vld_o && !ctx_vld_o); // R10
  AST_RESUME_TOP: assert property (@(posedge clk) disable iff (rst)
    resume_i |=> sp_o == SP_W'(DEPTH-1) && !pc_vld_o); // R11
endmodule

bind ret_addr_stack ras_checker #(.DEPTH(DEPTH), .SP_W(SP_W)) u_ras_checker (
  .clk       (clk),
  .rst       (rst),
  .resume_i  (resume_i),
  .call_i    (call_i),
  .irq_i     (irq_i),
  .tbl_i     (tbl_i),
  .ret_i     (ret_i),
  .reti_i    (reti_i),
  .tbl_end_i (tbl_end_i),
  .sp_o      (sp_o),
  .pc_vld_o  (pc_vld_o),
  .ctx_vld_o (ctx_vld_o),
  .shadow_q  (shadow_q)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  import ras_pkg::*;

  localparam int unsigned PC_W = 14;
  localparam int unsigned SP_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic resume_i = 0, call_i = 0, irq_i = 0, tbl_i = 0;
  logic ret_i = 0, reti_i = 0, tbl_end_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  ctx_t cin = '0;
  logic [SP_W-1:0] sp_o;
  logic [PC_W-1:0] pc_o;
  logic pc_vld_o, ctx_vld_o, carry_o, skip_o;
  logic [DP_W-1:0] dp_o;
  logic [NIB_W-1:0] a_o, b_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ret_addr_stack i_ret_addr_stack (
    .clk(clk), .rst(rst), .resume_i(resume_i),
    .call_i(call_i), .irq_i(irq_i), .tbl_i(tbl_i),
    .ret_i(ret_i), .reti_i(reti_i), .tbl_end_i(tbl_end_i),
    .pc_i(pc_i), .dp_i(cin.dp), .carry_i(cin.carry), .skip_i(cin.skip),
    .a_i(cin.a), .b_i(cin.b),
    .sp_o(sp_o), .pc_o(pc_o), .pc_vld_o(pc_vld_o), .ctx_vld_o(ctx_vld_o),
    .dp_o(dp_o), .carry_o(carry_o), .skip_o(skip_o), .a_o(a_o), .b_o(b_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // kind: 0 call, 1 interrupt, 2 table
  task automatic push(input int kind, input logic [PC_W-1:0] pc, input ctx_t c);
    pc_i = pc; cin = c;
    call_i = (kind == 0); irq_i = (kind == 1); tbl_i = (kind == 2);
    @(negedge clk);
    call_i = 0; irq_i = 0; tbl_i = 0;
  endtask

  // kind: 0 return, 1 return-from-interrupt, 2 table end
  task automatic pop(input int kind);
    ret_i = (kind == 0); reti_i = (kind == 1); tbl_end_i = (kind == 2);
    @(negedge clk);
    ret_i = 0; reti_i = 0; tbl_end_i = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 sp in reset", 32'(sp_o), 32'd7);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sp after reset", 32'(sp_o), 32'd7);
    chk("R1 pc_vld", 32'(pc_vld_o), 32'd0);
    chk("R1 ctx_vld", 32'(ctx_vld_o), 32'd0);
  endtask

  task automatic t_lifo();
    do_reset();
    push(0, 14'h0001, '0);
    chk("R3 first push selects entry 0", 32'(sp_o), 32'd0);
    push(2, 14'h0AAA, '0);
    chk("R2 R6 table push", 32'(sp_o), 32'd1);
    push(1, 14'h1234, '0);
    chk("R6 interrupt push", 32'(sp_o), 32'd2);
    pop(1);
    chk("R3 pop newest", 32'(pc_o), 32'h1234);
    chk("R3 pop valid", 32'(pc_vld_o), 32'd1);
    chk("R5 pop retreats", 32'(sp_o), 32'd1);
    @(negedge clk);
    chk("R3 valid lasts one cycle", 32'(pc_vld_o), 32'd0);
    pop(2);
    chk("R3 pop table entry", 32'(pc_o), 32'h0AAA);
    pop(0);
    chk("R3 pop oldest", 32'(pc_o), 32'h0001);
    chk("R5 back to top", 32'(sp_o), 32'd7);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 9; i++) push(0, 14'(16'h0100 + i), '0);
    chk("R4 ninth push wraps to 0", 32'(sp_o), 32'd0);
    pop(0);
    chk("R4 ninth address returned", 32'(pc_o), 32'h0109);
    chk("R5 wrap 0 to 7", 32'(sp_o), 32'd7);
    pop(0);
    chk("R4 eighth address returned", 32'(pc_o), 32'h0108);
  endtask

  task automatic t_underflow();
    do_reset();
    pop(0);
    chk("R5 empty pop wraps", 32'(sp_o), 32'd6);
    chk("R5 empty pop valid", 32'(pc_vld_o), 32'd1);
  endtask

  task automatic t_shadow();
    ctx_t c1 = '{dp: 6'h2B, carry: 1'b1, skip: 1'b1, a: 4'hA, b: 4'h5};
    ctx_t c2 = '{dp: 6'h11, carry: 1'b0, skip: 1'b0, a: 4'h3, b: 4'hC};
    do_reset();
    push(1, 14'h0200, c1);
    push(0, 14'h0300, c2);
    push(2, 14'h0400, ~c2);
    pop(2);
    chk("R8 table end no restore", 32'(ctx_vld_o), 32'd0);
    pop(0);
    chk("R8 return no restore", 32'(ctx_vld_o), 32'd0);
    pop(1);
    chk("R8 reti address", 32'(pc_o), 32'h0200);
    chk("R8 restore valid", 32'(ctx_vld_o), 32'd1);
    chk("R7 shadow kept across calls", 32'({dp_o, carry_o, skip_o, a_o, b_o}), 32'(c1));
    chk("R7 skip flag restored", 32'(skip_o), 32'd1);
  endtask

  task automatic t_depth();
    ctx_t c1 = '{dp: 6'h01, carry: 1'b0, skip: 1'b1, a: 4'h1, b: 4'h2};
    ctx_t c2 = '{dp: 6'h3E, carry: 1'b1, skip: 1'b0, a: 4'hE, b: 4'h7};
    do_reset();
    push(1, 14'h0010, c1);
    push(1, 14'h0020, c2);
    pop(1);
    chk("R9 latest capture", 32'({dp_o, carry_o, skip_o, a_o, b_o}), 32'(c2));
    pop(1);
    chk("R9 one stage only", 32'({dp_o, carry_o, skip_o, a_o, b_o}), 32'(c2));
    chk("R9 outer address", 32'(pc_o), 32'h0010);
  endtask

  task automatic t_conflict();
    do_reset();
    pc_i = 14'h0555; call_i = 1; ret_i = 1;
    @(negedge clk);
    call_i = 0; ret_i = 0;
    chk("R10 push wins pointer", 32'(sp_o), 32'd0);
    chk("R10 pop dropped", 32'(pc_vld_o), 32'd0);
    pop(0);
    chk("R10 pushed entry stored", 32'(pc_o), 32'h0555);
  endtask

  task automatic t_resume();
    do_reset();
    for (int i = 0; i < 8; i++) push(0, 14'(16'h0700 + i), '0);
    pop(0);
    chk("R11 setup pop", 32'(sp_o), 32'd6);
    resume_i = 1; ret_i = 1;
    @(negedge clk);
    resume_i = 0; ret_i = 0;
    chk("R11 pointer to top", 32'(sp_o), 32'd7);
    chk("R11 pop ignored", 32'(pc_vld_o), 32'd0);
    pop(0);
    chk("R11 entries kept", 32'(pc_o), 32'h0707);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_shadow();
    t_depth();
    t_conflict();
    t_resume();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule